// File: doc/BRIEF.md
# Posted Memory-Write Buffer with Burst Cut-Off

This block is the data path behind the write-target logic of a downstream bus port. Memory-write and memory-write-invalidate bursts arrive one 64-bit beat per cycle into a 1024-byte buffer. The block cuts a burst short by raising a disconnect when the burst reaches a 4 KB page edge or when the buffer runs out of room. The bus master then restarts the transfer at the next address with a new start beat.

Upstream, the stored beats leave as write packets that carry a start address, a length in beats and the data beats. Each packet is made as long as possible without crossing a 64-byte aligned line. A packet is released as soon as its line is complete, so draining overlaps the incoming burst. A single-beat I/O write is not buffered. It goes to a one-entry non-posted slot with its own handshake. Configuration writes are never taken.

Top module: `posted_wr_buf`

## Requirements
- R1: Command codes on `beat_cmd_i` are 0 memory write, 1 memory write invalidate, 2 I/O write and 3 configuration write. A memory beat is taken (`beat_ready_o` high) when it is a start beat with code 0 or 1, or a continuation beat of an open burst, and the buffer has a free entry.
- R2: A configuration write is never taken. It raises neither `beat_ready_o` nor `disc_o`, and it produces nothing on the upstream or non-posted outputs.
- R3: An I/O write start beat is taken when the non-posted slot is empty or is being emptied in the same cycle. `disc_o` is raised on that beat. From the next cycle the slot presents its address and data on the `io_*` outputs, and nothing goes upstream.
- R4: A taken memory beat whose last byte is the final byte of a 4 KB page raises `disc_o`. After that, a continuation beat without a new start is not taken.
- R5: The buffer holds 128 beats. The beat that takes the last free entry, as counted at the start of the cycle, raises `disc_o`. No memory beat is taken while no entry is free.
- R6: An upstream packet never crosses a 64-byte aligned boundary. It ends at such a boundary or at the last beat of a burst segment, so its length is the largest the burst allows. `up_len_o` is the length in beats on the start beat (`up_sop_o`), and `up_eop_o` marks the final beat.
- R7: A packet whose 64-byte line is complete is released while the burst is still arriving.
- R8: While `up_valid_o` is high and `up_ready_i` is low, the upstream outputs hold their values.
- R9: Data leave upstream in arrival order with their addresses intact. Every drained beat returns its entry, so the full 128 beats can be taken again after a drain.
- R10: After reset no output valid is high, and no beat is taken unless it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | A beat is presented |
| beat_start_i | input | 1 | First beat of a burst; command and address are valid |
| beat_end_i | input | 1 | Last beat the master intends to send |
| beat_cmd_i | input | 2 | Command code (see R1) |
| beat_addr_i | input | ADDR_W | Byte address of a start beat, 8-byte aligned |
| beat_data_i | input | DATA_W | Write data |
| beat_ready_o | output | 1 | The presented beat is taken this cycle |
| disc_o | output | 1 | Disconnect: this taken beat is the last of the burst |
| io_valid_o | output | 1 | Non-posted slot holds an I/O write |
| io_addr_o | output | ADDR_W | I/O write address |
| io_data_o | output | DATA_W | I/O write data |
| io_ready_i | input | 1 | Non-posted path takes the slot |
| up_valid_o | output | 1 | Upstream beat valid |
| up_sop_o | output | 1 | First beat of a packet |
| up_eop_o | output | 1 | Last beat of a packet |
| up_addr_o | output | ADDR_W | Address of the current beat (packet address on the start beat) |
| up_len_o | output | LEN_W | Packet length in beats on the start beat, zero otherwise |
| up_data_o | output | DATA_W | Upstream data |
| up_ready_i | input | 1 | Upstream takes the beat |

## Verification
The bench builds the block with its default parameters: a 40-bit address, a 64-bit data path, 1024 bytes of storage, 64-byte packets and 4 KB pages. With these values a single held-off burst of 128 beats fills the buffer. A burst started a few beats below a page edge reaches the page cut-off in under ten cycles. Bursts that start in the middle of a line exercise packets shorter than a full line at both ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    CMD_MW   = 2'd0,
    CMD_MWI  = 2'd1,
    CMD_IOW  = 2'd2,
    CMD_CFGW = 2'd3
  } cmd_e;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int W     = 105,
  parameter int DEPTH = 128,
  parameter int PEEK  = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [W-1:0]    push_data_i,
  input  logic            pop_i,
  output logic [W-1:0]    head_o,
  output logic [PEEK-1:0] peek_last_o,
  output logic [CW-1:0]   count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;

  // bit 0 of each entry is the segment-last flag
  for (genvar i = 0; i < PEEK; i++) begin : g_peek
    assign peek_last_o[i] = mem[rd_ptr_q + PW'(i)][0];
  end
endmodule

// File: rtl/pwb_ingress.sv
module pwb_ingress
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 64,
  parameter int DEPTH      = 128,
  parameter int PAGE_BYTES = 4096,
  localparam int OFF_LSB   = $clog2(DATA_W / 8),
  localparam int PG_MSB    = $clog2(PAGE_BYTES),
  localparam int FW        = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic              beat_start_i,
  input  logic              beat_end_i,
  input  logic [1:0]        beat_cmd_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  input  logic [DATA_W-1:0] beat_data_i,
  output logic              beat_ready_o,
  output logic              disc_o,
  input  logic              drain_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic              push_last_o,
  output logic [FW-1:0]     free_o,
  output logic              io_valid_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [DATA_W-1:0] io_data_o,
  input  logic              io_ready_i
);
  logic              active_q;
  logic [ADDR_W-1:0] next_addr_q;
  logic [FW-1:0]     free_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              is_mem, mem_take, io_take, page_end, full_hit;

  assign is_mem   = (beat_cmd_i == CMD_MW) || (beat_cmd_i == CMD_MWI);
  assign cur_addr = beat_start_i ? beat_addr_i : next_addr_q;
  assign page_end = &cur_addr[PG_MSB-1:OFF_LSB];
  assign full_hit = (free_q == FW'(1));
  assign mem_take = beat_valid_i && (beat_start_i ? is_mem : active_q) && (free_q != '0);
  assign io_take  = beat_valid_i && beat_start_i && (beat_cmd_i == CMD_IOW)
                    && (!io_valid_o || io_ready_i);

  assign beat_ready_o = mem_take || io_take;
  assign disc_o       = io_take || (mem_take && (page_end || full_hit));
  assign push_o       = mem_take;
  assign push_addr_o  = cur_addr;
  assign push_last_o  = beat_end_i || page_end || full_hit;
  assign free_o       = free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      next_addr_q <= '0;
      free_q      <= FW'(DEPTH);
      io_valid_o  <= 1'b0;
      io_addr_o   <= '0;
      io_data_o   <= '0;
    end else begin
      if (mem_take) begin
        active_q    <= !push_last_o;
        next_addr_q <= cur_addr + ADDR_W'(DATA_W / 8);
      end else if (beat_valid_i && beat_start_i) begin
        active_q <= 1'b0;
      end
      free_q <= free_q - FW'(mem_take) + FW'(drain_i);
      if (io_take) begin
        io_valid_o <= 1'b1;
        io_addr_o  <= beat_addr_i;
        io_data_o  <= beat_data_i;
      end else if (io_ready_i) begin
        io_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwb_pkt_former.sv
module pwb_pkt_former #(
  parameter int ADDR_W    = 40,
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 128,
  parameter int PKT_BEATS = 8,
  localparam int OFF_LSB  = $clog2(DATA_W / 8),
  localparam int PB_W     = $clog2(PKT_BEATS),
  localparam int LEN_W    = PB_W + 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    head_addr_i,
  input  logic [DATA_W-1:0]    head_data_i,
  input  logic [PKT_BEATS-1:0] peek_last_i,
  input  logic [CW-1:0]        count_i,
  output logic                 pop_o,
  output logic                 up_valid_o,
  output logic                 up_sop_o,
  output logic                 up_eop_o,
  output logic [ADDR_W-1:0]    up_addr_o,
  output logic [LEN_W-1:0]     up_len_o,
  output logic [DATA_W-1:0]    up_data_o,
  input  logic                 up_ready_i
);
  logic [LEN_W-1:0] rem_q, span, hdr_len;
  logic             hdr_ok, stop;

  assign span = LEN_W'(PKT_BEATS) - LEN_W'(head_addr_i[OFF_LSB +: PB_W]);

  // packet ready once its line is present or a segment end lies inside it
  always_comb begin
    hdr_ok  = 1'b0;
    hdr_len = '0;
    stop    = 1'b0;
    for (int i = 0; i < PKT_BEATS; i++) begin
      if (!stop) begin
        if (LEN_W'(i) >= span || count_i <= CW'(i)) begin
          stop = 1'b1;
        end else if (peek_last_i[i] || LEN_W'(i + 1) == span) begin
          hdr_ok  = 1'b1;
          hdr_len = LEN_W'(i + 1);
          stop    = 1'b1;
        end
      end
    end
  end

  assign up_sop_o   = (rem_q == '0) && hdr_ok;
  assign up_valid_o = (rem_q != '0) || hdr_ok;
  assign up_eop_o   = (rem_q == LEN_W'(1)) || (up_sop_o && hdr_len == LEN_W'(1));
  assign up_len_o   = up_sop_o ? hdr_len : '0;
  assign up_addr_o  = head_addr_i;
  assign up_data_o  = head_data_i;
  assign pop_o      = up_valid_o && up_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rem_q <= '0;
    else if (pop_o) rem_q <= up_sop_o ? hdr_len - LEN_W'(1) : rem_q - LEN_W'(1);
  end
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 64,
  parameter int BUF_BYTES  = 1024,
  parameter int PKT_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  localparam int DEPTH     = BUF_BYTES / (DATA_W / 8),
  localparam int PKT_BEATS = PKT_BYTES / (DATA_W / 8),
  localparam int LEN_W     = $clog2(PKT_BEATS) + 1,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int ENT_W     = ADDR_W + DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic              beat_start_i,
  input  logic              beat_end_i,
  input  logic [1:0]        beat_cmd_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  input  logic [DATA_W-1:0] beat_data_i,
  output logic              beat_ready_o,
  output logic              disc_o,
  output logic              io_valid_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [DATA_W-1:0] io_data_o,
  input  logic              io_ready_i,
  output logic              up_valid_o,
  output logic              up_sop_o,
  output logic              up_eop_o,
  output logic [ADDR_W-1:0] up_addr_o,
  output logic [LEN_W-1:0]  up_len_o,
  output logic [DATA_W-1:0] up_data_o,
  input  logic              up_ready_i
);
  logic                 push, push_last, drain;
  logic [ADDR_W-1:0]    push_addr;
  logic [CW-1:0]        free_cnt, count;
  logic [ENT_W-1:0]     head;
  logic [PKT_BEATS-1:0] peek_last;

  pwb_ingress #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)
  ) u_ingress (
    .clk_i, .rst_ni, .beat_valid_i, .beat_start_i, .beat_end_i, .beat_cmd_i,
    .beat_addr_i, .beat_data_i, .beat_ready_o, .disc_o,
    .drain_i(drain), .push_o(push), .push_addr_o(push_addr),
    .push_last_o(push_last), .free_o(free_cnt),
    .io_valid_o, .io_addr_o, .io_data_o, .io_ready_i
  );

  pwb_fifo #(.W(ENT_W), .DEPTH(DEPTH), .PEEK(PKT_BEATS)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i({push_addr, beat_data_i, push_last}),
    .pop_i(drain), .head_o(head), .peek_last_o(peek_last), .count_o(count)
  );

  pwb_pkt_former #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PKT_BEATS(PKT_BEATS)
  ) u_former (
    .clk_i, .rst_ni,
    .head_addr_i(head[ENT_W-1 -: ADDR_W]), .head_data_i(head[DATA_W:1]),
    .peek_last_i(peek_last), .count_i(count), .pop_o(drain),
    .up_valid_o, .up_sop_o, .up_eop_o, .up_addr_o, .up_len_o, .up_data_o, .up_ready_i
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 64,
  parameter int DEPTH      = 128,
  parameter int PKT_BEATS  = 8,
  parameter int PAGE_BYTES = 4096,
  localparam int OFF_LSB   = $clog2(DATA_W / 8),
  localparam int PB_W      = $clog2(PKT_BEATS),
  localparam int LEN_W     = PB_W + 1,
  localparam int PG_MSB    = $clog2(PAGE_BYTES),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              beat_valid_i,
  input logic              beat_start_i,
  input logic [1:0]        beat_cmd_i,
  input logic [ADDR_W-1:0] beat_addr_i,
  input logic              beat_ready_o,
  input logic              disc_o,
  input logic              io_valid_o,
  input logic              up_valid_o,
  input logic              up_sop_o,
  input logic [ADDR_W-1:0] up_addr_o,
  input logic [LEN_W-1:0]  up_len_o,
  input logic [DATA_W-1:0] up_data_o,
  input logic              up_ready_i,
  input logic [CW-1:0]     free_cnt
);
  logic              io_beat, mem_acc;
  logic [ADDR_W-1:0] nxt_q, ck_addr;

  assign io_beat = beat_start_i && (beat_cmd_i == 2'd2);
  assign mem_acc = beat_ready_o && !io_beat;
  assign ck_addr = beat_start_i ? beat_addr_i : nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nxt_q <= '0;
    else if (mem_acc) nxt_q <= ck_addr + ADDR_W'(DATA_W / 8);
  end

  assert_cfg_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_i && beat_start_i && beat_cmd_i == 2'd3 |-> !beat_ready_o && !disc_o);

  assert_io_disc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_ready_o && io_beat |-> disc_o);

  assert_io_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_ready_o && io_beat |=> io_valid_o);

  assert_page_disc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_acc && (&ck_addr[PG_MSB-1:OFF_LSB]) |-> disc_o);

  assert_no_continue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_acc && disc_o |=> !(beat_valid_i && !beat_start_i && beat_ready_o));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt == '0 |-> !mem_acc);

  assert_free_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt <= CW'(DEPTH));

  assert_pkt_in_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o && up_sop_o |->
      up_len_o != '0 && (LEN_W'(up_addr_o[OFF_LSB +: PB_W]) + up_len_o) <= LEN_W'(PKT_BEATS));

  assert_hold_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o && !up_ready_i |=> up_valid_o && $stable(up_data_o) && $stable(up_addr_o)
      && $stable(up_sop_o) && $stable(up_len_o));
endmodule

bind posted_wr_buf pwb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
  .PKT_BEATS(PKT_BEATS), .PAGE_BYTES(PAGE_BYTES)
) u_pwb_checker (
  .clk_i, .rst_ni, .beat_valid_i, .beat_start_i, .beat_cmd_i, .beat_addr_i,
  .beat_ready_o, .disc_o, .io_valid_o, .up_valid_o, .up_sop_o, .up_addr_o,
  .up_len_o, .up_data_o, .up_ready_i, .free_cnt(free_cnt)
);

// File: tb/posted_wr_buf_bench.sv
module posted_wr_buf_bench;
  localparam int AW = 40;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          beat_valid = 1'b0, beat_start = 1'b0, beat_end = 1'b0;
  logic [1:0]    beat_cmd = 2'd0;
  logic [AW-1:0] beat_addr = '0;
  logic [DW-1:0] beat_data = '0;
  logic          beat_ready, disc;
  logic          io_valid, io_ready = 1'b0;
  logic [AW-1:0] io_addr;
  logic [DW-1:0] io_data;
  logic          up_valid, up_sop, up_eop, up_ready = 1'b1;
  logic [AW-1:0] up_addr;
  logic [3:0]    up_len;
  logic [DW-1:0] up_data;
  logic          tog = 1'b0;

  int checks = 0, errors = 0;
  bit sop_seen = 0;

  typedef struct { logic [AW-1:0] addr; int len; } pkt_t;
  pkt_t exp_q[$];

  always #2 clk = ~clk;

  posted_wr_buf u_posted_wr_buf (
    .clk_i(clk), .rst_ni(rst_ni), .beat_valid_i(beat_valid), .beat_start_i(beat_start),
    .beat_end_i(beat_end), .beat_cmd_i(beat_cmd), .beat_addr_i(beat_addr),
    .beat_data_i(beat_data), .beat_ready_o(beat_ready), .disc_o(disc),
    .io_valid_o(io_valid), .io_addr_o(io_addr), .io_data_o(io_data), .io_ready_i(io_ready),
    .up_valid_o(up_valid), .up_sop_o(up_sop), .up_eop_o(up_eop), .up_addr_o(up_addr),
    .up_len_o(up_len), .up_data_o(up_data), .up_ready_i(up_ready)
  );

  function automatic logic [DW-1:0] dat(logic [AW-1:0] a);
    return {a[23:0], a} ^ 64'h5A00_0000_0000_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (tog) up_ready = ~up_ready;

  // monitor: pops expected packets and compares each upstream beat
  pkt_t cur;
  int   bi = 0;
  initial begin
    cur.addr = '0; cur.len = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_ni && up_valid && up_ready) begin
        if (up_sop) begin
          sop_seen = 1;
          if (exp_q.size() == 0) begin
            chk(0, "R9", "unexpected packet", up_addr, 0);
            cur.addr = up_addr; cur.len = int'(up_len);
          end else begin
            cur = exp_q.pop_front();
            chk(up_addr == cur.addr, "R6", "packet addr", up_addr, cur.addr);
            chk(int'(up_len) == cur.len, "R6", "packet len", up_len, cur.len);
          end
          bi = 0;
        end
        chk(up_data == dat(cur.addr + AW'(8 * bi)), "R9", "beat data", up_data,
            dat(cur.addr + AW'(8 * bi)));
        chk(up_eop == (bi == cur.len - 1), "R6", "eop", up_eop, bi == cur.len - 1);
        bi++;
      end
    end
  end

  // driver: sends a burst, restarts after disconnect, predicts packets
  task automatic send(input logic [1:0] cmd, input logic [AW-1:0] addr, input int n,
                      input int full_idx, input int stream_at);
    logic [AW-1:0] a = addr, ch_addr = addr;
    int  ch_len = 0;
    bit  first = 1, exp_disc, pg, seg_end;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      beat_valid = 1; beat_start = first; beat_end = (i == n - 1);
      beat_cmd = cmd; beat_addr = a; beat_data = dat(a);
      #1;
      if (i == stream_at) chk(sop_seen, "R7", "packet before burst end", sop_seen, 1);
      pg = (a[11:3] == 9'h1FF);
      exp_disc = pg || (i == full_idx);
      chk(beat_ready == 1'b1, "R1", "beat taken", beat_ready, 1);
      if (pg) chk(disc == 1'b1, "R4", "page disconnect", disc, 1);
      else if (i == full_idx) chk(disc == 1'b1, "R5", "full disconnect", disc, 1);
      else chk(disc == 1'b0, "R1", "no disconnect", disc, 0);
      if (!beat_ready) break;
      ch_len++;
      seg_end = beat_end || exp_disc;
      if (a[5:3] == 3'h7 || seg_end) begin
        exp_q.push_back('{ch_addr, ch_len});
        ch_addr = a + AW'(8); ch_len = 0;
      end
      a = a + AW'(8);
      first = exp_disc;
      if (i == full_idx) break;
    end
    @(negedge clk);
    beat_valid = 0; beat_start = 0; beat_end = 0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      if (exp_q.size() == 0 && !up_valid) break;
    end
    chk(exp_q.size() == 0, "R9", "all packets drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!up_valid, "R10", "reset up_valid", up_valid, 0);
    chk(!io_valid, "R10", "reset io_valid", io_valid, 0);
    chk(!beat_ready, "R10", "reset beat_ready", beat_ready, 0);
    rst_ni = 1;

    // aligned 16-beat write-invalidate burst, streaming
    sop_seen = 0;
    send(2'd1, 40'h400, 16, -1, 12);
    wait_drain();

    // unaligned burst with toggling upstream ready
    tog = 1;
    send(2'd0, 40'h108, 12, -1, -1);
    wait_drain();
    tog = 0; up_ready = 1;

    // single beat and page edge
    send(2'd0, 40'h200, 1, -1, -1);
    send(2'd0, 40'h2FD0, 10, -1, -1);
    wait_drain();

    // continuation beat with no open burst is ignored
    @(negedge clk);
    beat_valid = 1; beat_start = 0; beat_cmd = 2'd0; #1;
    chk(!beat_ready, "R4", "continuation without start", beat_ready, 0);
    @(negedge clk); beat_valid = 0;

    // configuration write
    @(negedge clk);
    beat_valid = 1; beat_start = 1; beat_cmd = 2'd3; beat_addr = 40'h80; #1;
    chk(!beat_ready, "R2", "config not taken", beat_ready, 0);
    chk(!disc, "R2", "config no disconnect", disc, 0);
    repeat (2) @(negedge clk);
    beat_valid = 0; beat_start = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!up_valid && !io_valid, "R2", "config no output", {up_valid, io_valid}, 0);

    // I/O write
    io_ready = 0;
    @(negedge clk);
    beat_valid = 1; beat_start = 1; beat_cmd = 2'd2; beat_addr = 40'h58;
    beat_data = 64'h1234_5678_9ABC_DEF0; #1;
    chk(beat_ready, "R3", "io taken", beat_ready, 1);
    chk(disc, "R3", "io disconnect", disc, 1);
    @(negedge clk);
    beat_addr = 40'h60; #1;
    chk(io_valid, "R3", "io slot valid", io_valid, 1);
    chk(io_addr == 40'h58, "R3", "io addr", io_addr, 40'h58);
    chk(io_data == 64'h1234_5678_9ABC_DEF0, "R3", "io data", io_data, 64'h1234_5678_9ABC_DEF0);
    chk(!beat_ready, "R3", "io slot busy", beat_ready, 0);
    chk(!up_valid, "R3", "io not upstream", up_valid, 0);
    beat_valid = 0; beat_start = 0;
    @(negedge clk); io_ready = 1;
    @(negedge clk); #1;
    chk(!io_valid, "R3", "io slot emptied", io_valid, 0);
    io_ready = 0;

    // fill the buffer with upstream held off
    up_ready = 0;
    send(2'd0, 40'h1000, 130, 127, -1);
    beat_valid = 1; beat_start = 0; beat_cmd = 2'd0; #1;
    chk(!beat_ready, "R5", "continuation when full", beat_ready, 0);
    @(negedge clk);
    beat_start = 1; beat_addr = 40'h1400; #1;
    chk(!beat_ready, "R5", "new burst when full", beat_ready, 0);
    @(negedge clk);
    beat_valid = 0; beat_start = 0; #1;
    chk(up_valid && up_sop && up_len == 4'd8, "R8", "stalled head packet",
        {up_valid, up_sop, up_len}, {1'b1, 1'b1, 4'd8});
    up_ready = 1;
    wait_drain();

    // capacity restored after drain
    up_ready = 0;
    send(2'd1, 40'h2000, 128, 127, -1);
    up_ready = 1;
    wait_drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule